// File: doc/BRIEF.md
# Horizontal Polyphase Pixel Scaler

This block resizes one 8-bit colour component along a scan line. A line of input pixels arrives over a valid/ready stream and is stored whole. The block then walks a phase accumulator across the stored line and produces one resampled pixel per clock. Each output pixel is the weighted sum of five neighbouring input pixels. The weights come from a coefficient set with eight phases, and the phase is picked by the top bits of the accumulator. The sum is rounded, scaled back down and clamped to full range or to video range.

Two independent coefficient banks are held in the block, one for luma/alpha/RGB work and one for chroma, and a select input picks the bank for the current line. Coefficients are written one at a time through a small write port while resizing is switched off. When resizing is switched off, pixels stream straight through with one register of delay.

Top module: `hscale_poly`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Both coefficient banks hold the identity set: the centre tap is 128 and every other tap is 0 in all eight phases. With these banks, a resized line at step 1024 reproduces its input.
- R2: With `scale_en`=1, `in_ready` stays 1 while a line is being collected. A line closes on the pixel accepted with `in_last`=1. From the next cycle `in_ready` is 0 and outputs are produced. Output k of the line shows on `out_valid` in the register stage k+1 clocks after the edge that accepted the closing pixel. The final output carries `out_last`=1, and `in_ready` returns to 1 in that same cycle.
- R3: Each line of N pixels starts with accumulator 0 and centre index 0. After each output the accumulator adds `step` (legal range 1 to 1024) modulo 1024. The centre index advances by one whenever the 11-bit sum reaches 1024. The line ends with the output whose advance would move the centre past index N-1.
- R4: For output k with centre c, the filter computes the sum of coef[t]*pixel[c+t-2] for t = 0..4. Neighbours before the first pixel or after the last pixel are replaced by the first or last pixel. Taps 0, 1, 3 and 4 are signed two's-complement bytes. Tap 2, the centre, is an unsigned byte.
- R5: The sum has 64 added and is then shifted right arithmetically by 7. With `full_range`=1 the result is clamped to [0,255]; with `full_range`=0 it is clamped to [16,240].
- R6: With `scale_en`=0 every input pixel is accepted (`in_ready`=1). It appears one clock later on `out_data` unchanged and unclamped, and `out_last` copies `in_last`.
- R7: A coefficient write takes effect on a rising edge with `cw_en`=1 and `scale_en`=0. `cw_tap` values 0..4 mean offsets -2..+2, and values 5..7 are ignored. A write attempted while `scale_en`=1 leaves the bank unchanged.
- R8: `cw_bank`=0 addresses the luma/ARGB bank and `cw_bank`=1 the chroma bank. `sel_chroma` chooses the bank used to filter a line.
- R9: The phase used for an output is accumulator bits [9:7], i.e. the accumulator divided by 128. Phase 0 covers 0..127 and phase 7 covers 896..1023.
- R10: A line holds at most MAX_PIX pixels (default 64). The MAX_PIX-th accepted pixel closes the line even when `in_last` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scale_en | input | 1 | 1 = resize lines, 0 = pass pixels through |
| full_range | input | 1 | 1 = clamp to [0,255], 0 = clamp to [16,240] |
| sel_chroma | input | 1 | Coefficient bank used for filtering |
| step | input | 11 | Accumulator increment per output, 1..1024 |
| cw_en | input | 1 | Coefficient write strobe |
| cw_bank | input | 1 | Bank written |
| cw_phase | input | 3 | Phase written |
| cw_tap | input | 3 | Tap written, 0..4 = offset -2..+2 |
| cw_data | input | 8 | Coefficient byte |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when valid |
| in_data | input | 8 | Input pixel |
| in_last | input | 1 | Input pixel closes the line |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 8 | Output pixel |
| out_last | output | 1 | Output pixel closes the line |

## Verification
In resize mode, output k of a line is due in the register stage k+1 clocks after the edge that accepted the closing pixel. In pass-through mode the pixel is due from the same edge that accepted it. The bench model stamps every expected pixel with its due cycle, counted in rising edges, and compares data, last flag and cycle on each falling edge where `out_valid` is high. An output that comes early, late or unexpected is therefore reported, and a missing one leaves the queue non-empty at the end.

// File: rtl/hps_pkg.sv
`timescale 1ns/1ps
package hps_pkg;
  localparam int PIX_W   = 8;
  localparam int COEF_W  = 8;
  localparam int NTAP    = 5;
  localparam int CTR_TAP = 2;
  localparam int NPH     = 8;
  localparam int PH_W    = $clog2(NPH);
  localparam int TAP_W   = $clog2(NTAP);
  localparam int ACC_W   = 10;
  localparam int SHIFT   = 7;
  localparam int NBANK   = 2;
  localparam int SUM_W   = PIX_W + COEF_W + 5;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [COEF_W-1:0] coef_t;
  typedef enum logic {S_FILL, S_RUN} st_e;

  localparam logic signed [SUM_W-1:0] RND   = SUM_W'(1 << (SHIFT - 1));
  localparam logic signed [SUM_W-1:0] LO_V  = SUM_W'(16);
  localparam logic signed [SUM_W-1:0] HI_V  = SUM_W'(240);
  localparam logic signed [SUM_W-1:0] HI_F  = SUM_W'((1 << PIX_W) - 1);
  localparam coef_t                   UNITY = COEF_W'(1 << SHIFT);

  // One product: centre coefficient is unsigned, the others signed.
  function automatic logic signed [SUM_W-1:0] tap_term(coef_t c, pix_t p, logic centre);
    logic signed [SUM_W-1:0] cw, pw;
    cw = centre ? SUM_W'($signed({1'b0, c})) : SUM_W'($signed(c));
    pw = SUM_W'($signed({1'b0, p}));
    return cw * pw;
  endfunction

  // Round half up, divide by 2^SHIFT, clamp to the selected range.
  function automatic pix_t round_clamp(logic signed [SUM_W-1:0] s, logic full);
    logic signed [SUM_W-1:0] r, lo, hi;
    r  = (s + RND) >>> SHIFT;
    lo = full ? '0 : LO_V;
    hi = full ? HI_F : HI_V;
    if (r < lo)      return lo[PIX_W-1:0];
    else if (r > hi) return hi[PIX_W-1:0];
    else             return r[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/hps_coef_bank.sv
`timescale 1ns/1ps
module hps_coef_bank
  import hps_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lock,
  input  logic                         wr_en,
  input  logic                         wr_bank,
  input  logic [PH_W-1:0]              wr_phase,
  input  logic [TAP_W-1:0]             wr_tap,
  input  coef_t                        wr_data,
  input  logic                         rd_bank,
  input  logic [PH_W-1:0]              rd_phase,
  output logic [NTAP-1:0][COEF_W-1:0]  rd_taps
);
  logic [NBANK-1:0][NPH-1:0][NTAP-1:0][COEF_W-1:0] store;
  logic wr_hit;

  assign wr_hit = wr_en && !lock && (wr_tap < TAP_W'(NTAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int p = 0; p < NPH; p++)
          for (int t = 0; t < NTAP; t++)
            store[b][p][t] <= (t == CTR_TAP) ? UNITY : '0;
    end else if (wr_hit) begin
      store[wr_bank][wr_phase][wr_tap] <= wr_data;
    end
  end

  assign rd_taps = store[rd_bank][rd_phase];

  // R7: while locked, no coefficient may change
  p_bank_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(store));
endmodule

// File: rtl/hps_line_buf.sv
`timescale 1ns/1ps
module hps_line_buf
  import hps_pkg::*;
#(
  parameter int MAX_PIX = 64,
  parameter int IDX_W   = $clog2(MAX_PIX)
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  pix_t                        wr_data,
  input  logic [IDX_W-1:0]            ctr,
  input  logic [IDX_W-1:0]            last_idx,
  output logic [NTAP-1:0][PIX_W-1:0]  win
);
  pix_t mem [MAX_PIX];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // One read port per tap, neighbour index clipped to the line edges.
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    localparam int OFS = t - CTR_TAP;
    logic signed [IDX_W+1:0] pos;
    logic [IDX_W-1:0]        sel;
    always_comb begin
      pos = $signed({2'b00, ctr}) + $signed((IDX_W+2)'(OFS));
      if (pos[IDX_W+1])                           sel = '0;
      else if (pos > $signed({2'b00, last_idx}))  sel = last_idx;
      else                                        sel = pos[IDX_W-1:0];
    end
    assign win[t] = mem[sel];
  end
endmodule

// File: rtl/hps_fir.sv
`timescale 1ns/1ps
module hps_fir
  import hps_pkg::*;
(
  input  logic [NTAP-1:0][PIX_W-1:0]  win,
  input  logic [NTAP-1:0][COEF_W-1:0] taps,
  input  logic                        full_range,
  output pix_t                        pix_o
);
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int t = 0; t < NTAP; t++)
      sum = sum + tap_term(taps[t], win[t], t == CTR_TAP);
  end

  assign pix_o = round_clamp(sum, full_range);
endmodule

// File: rtl/hscale_poly.sv
`timescale 1ns/1ps
module hscale_poly
  import hps_pkg::*;
#(
  parameter int MAX_PIX = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scale_en,
  input  logic               full_range,
  input  logic               sel_chroma,
  input  logic [ACC_W:0]     step,
  input  logic               cw_en,
  input  logic               cw_bank,
  input  logic [PH_W-1:0]    cw_phase,
  input  logic [TAP_W-1:0]   cw_tap,
  input  logic [COEF_W-1:0]  cw_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_data,
  input  logic               in_last,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_data,
  output logic               out_last
);
  localparam int IDX_W = $clog2(MAX_PIX);

  st_e               state;
  logic [IDX_W-1:0]  wr_idx, last_idx, ctr;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W:0]    acc_nxt;
  logic              adv, fin, take, fill_wr, line_end;
  logic              out_filt, out_rng;
  logic [PH_W-1:0]   phase;
  logic [NTAP-1:0][PIX_W-1:0]  win;
  logic [NTAP-1:0][COEF_W-1:0] taps;
  pix_t              fir_pix;

  assign in_ready = !scale_en || (state == S_FILL);
  assign take     = in_valid && in_ready;
  assign fill_wr  = take && scale_en;
  assign line_end = fill_wr && (in_last || wr_idx == IDX_W'(MAX_PIX - 1));
  assign acc_nxt  = {1'b0, acc} + step;
  assign adv      = acc_nxt[ACC_W];
  assign fin      = (state == S_RUN) && adv && (ctr == last_idx);
  assign phase    = acc[ACC_W-1 -: PH_W];

  hps_coef_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock     (scale_en),
    .wr_en    (cw_en),
    .wr_bank  (cw_bank),
    .wr_phase (cw_phase),
    .wr_tap   (cw_tap),
    .wr_data  (cw_data),
    .rd_bank  (sel_chroma),
    .rd_phase (phase),
    .rd_taps  (taps)
  );

  hps_line_buf #(.MAX_PIX(MAX_PIX), .IDX_W(IDX_W)) u_line (
    .clk      (clk),
    .wr_en    (fill_wr),
    .wr_idx   (wr_idx),
    .wr_data  (in_data),
    .ctr      (ctr),
    .last_idx (last_idx),
    .win      (win)
  );

  hps_fir u_fir (
    .win        (win),
    .taps       (taps),
    .full_range (full_range),
    .pix_o      (fir_pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_FILL;
      wr_idx    <= '0;
      last_idx  <= '0;
      ctr       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_filt  <= 1'b0;
      out_rng   <= 1'b0;
    end else if (!scale_en) begin
      state     <= S_FILL;
      wr_idx    <= '0;
      out_valid <= in_valid;
      out_data  <= in_data;
      out_last  <= in_last;
      out_filt  <= 1'b0;
    end else begin
      unique case (state)
        S_FILL: begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          out_filt  <= 1'b0;
          if (fill_wr) begin
            if (line_end) begin
              last_idx <= wr_idx;
              wr_idx   <= '0;
              ctr      <= '0;
              acc      <= '0;
              state    <= S_RUN;
            end else begin
              wr_idx <= wr_idx + 1'b1;
            end
          end
        end
        S_RUN: begin
          out_valid <= 1'b1;
          out_data  <= fir_pix;
          out_last  <= fin;
          out_filt  <= 1'b1;
          out_rng   <= full_range;
          acc       <= acc_nxt[ACC_W-1:0];
          if (adv) ctr <= ctr + 1'b1;
          if (fin) state <= S_FILL;
        end
        default: state <= S_FILL;
      endcase
    end
  end

  // R3: the centre never walks beyond the stored line
  p_center_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> (ctr <= last_idx));

  // R2: the closing output coincides with input becoming acceptable again
  p_last_reopens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_filt && out_last && scale_en) |-> in_ready);

  // R5: video-range results stay inside [16,240]
  p_vid_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_filt && !out_rng) |-> (out_data >= 8'd16 && out_data <= 8'd240));

  // R6: bypass forwards the pixel unchanged one clock later
  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scale_en && in_valid) |=> (out_valid && out_data == $past(in_data) && out_last == $past(in_last)));
endmodule

// File: tb/test_hscale_poly.sv
`timescale 1ns/1ps
module test_hscale_poly;
  localparam int MAXP = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scale_en = 1'b0, full_range = 1'b1, sel_chroma = 1'b0;
  logic [10:0] step = 11'd1024;
  logic cw_en = 1'b0, cw_bank = 1'b0;
  logic [2:0] cw_phase = '0, cw_tap = '0;
  logic [7:0] cw_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  hscale_poly #(.MAX_PIX(MAXP)) i_hscale_poly (
    .clk(clk), .rst_n(rst_n), .scale_en(scale_en), .full_range(full_range),
    .sel_chroma(sel_chroma), .step(step), .cw_en(cw_en), .cw_bank(cw_bank),
    .cw_phase(cw_phase), .cw_tap(cw_tap), .cw_data(cw_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int cf [2][8][5];
  bit en_m = 0, full_m = 1, sel_m = 0;
  int step_m = 1024;
  int line_q[$];
  int exp_d[$], exp_l[$], exp_t[$];
  string exp_tag[$];
  string cur_tag = "R1";

  task automatic chk(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int coefv(int b, int p, int t);
    int v = cf[b][p][t];
    if (t != 2 && v >= 128) v -= 256;
    return v;
  endfunction

  // Behavioural model of one resized line
  function automatic void emit_line(int base);
    int n = line_q.size();
    int c = 0, a = 0, k = 0;
    while (c < n) begin
      int ph = a / 128;
      int s = 0, v, nx;
      bit adv;
      for (int t = 0; t < 5; t++) begin
        int ix = c + t - 2;
        if (ix < 0) ix = 0;
        if (ix > n - 1) ix = n - 1;
        s += coefv(sel_m, ph, t) * line_q[ix];
      end
      v = s + 64;
      v = (v >= 0) ? v / 128 : -((-v + 127) / 128);
      if (full_m) begin
        if (v < 0) v = 0;
        if (v > 255) v = 255;
      end else begin
        if (v < 16) v = 16;
        if (v > 240) v = 240;
      end
      nx  = a + step_m;
      adv = (nx >= 1024);
      a   = nx % 1024;
      exp_d.push_back(v);
      exp_l.push_back(int'(adv && c == n - 1));
      exp_t.push_back(base + k);
      exp_tag.push_back(cur_tag);
      k++;
      if (adv) c++;
    end
    line_q.delete();
  endfunction

  function automatic void model_accept(int d, bit last, int edge_n);
    if (en_m) begin
      line_q.push_back(d);
      if (last || line_q.size() == MAXP) emit_line(edge_n + 1);
    end else begin
      exp_d.push_back(d);
      exp_l.push_back(int'(last));
      exp_t.push_back(edge_n);
      exp_tag.push_back(cur_tag);
    end
  endfunction

  // Output monitor: value, last flag and due cycle on every falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (exp_d.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected output %0d, expected none", out_data);
      end else begin
        int d, l, t;
        string tg;
        d = exp_d.pop_front(); l = exp_l.pop_front();
        t = exp_t.pop_front(); tg = exp_tag.pop_front();
        if (out_data !== 8'(d) || out_last !== l[0] || cyc != t) begin
          n_bad++;
          $display("FAIL %s: actual data %0d last %0b cycle %0d expected data %0d last %0d cycle %0d",
                   tg, out_data, out_last, cyc, d, l, t);
        end
      end
    end
  end

  task automatic send_pix(int d, bit last);
    in_valid = 1'b1; in_data = 8'(d); in_last = last;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    model_accept(d, last, cyc + 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_line(int px[$], bit closed);
    foreach (px[i]) send_pix(px[i], closed && (i == px.size() - 1));
  endtask

  task automatic idle();
    while (exp_d.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(bit en, bit full, bit sel, int st);
    scale_en = en; full_range = full; sel_chroma = sel; step = 11'(st);
    en_m = en; full_m = full; sel_m = sel; step_m = st;
    @(negedge clk);
  endtask

  task automatic wcoef(int b, int p, int t, int v);
    cw_en = 1'b1; cw_bank = b[0]; cw_phase = 3'(p); cw_tap = 3'(t); cw_data = 8'(v & 255);
    if (!scale_en && t < 5) cf[b][p][t] = v & 255;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 8; p++)
        for (int t = 0; t < 5; t++) cf[b][p][t] = (t == 2) ? 128 : 0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R1/R2: identity banks at unit step reproduce the line
    cur_tag = "R1 R2 identity line";
    cfg(1, 1, 0, 1024);
    send_line('{10, 200, 0, 255, 37, 99}, 1);
    chk(in_ready == 1'b0, "R2 in_ready low while emitting", in_ready, 0);
    idle();

    // R3/R9: step 512 gives two outputs per input, phases 0 and 4
    cur_tag = "R3 R9 step 512";
    cfg(1, 1, 0, 512);
    send_line('{5, 60, 120, 180, 250}, 1);
    idle();

    // R4/R5/R7/R9: programmed luma bank with signed taps and unsigned centre
    cfg(0, 1, 0, 1024);
    for (int p = 0; p < 8; p++) begin
      wcoef(0, p, 0, -(2 + p));
      wcoef(0, p, 1, 24 + 3 * p);
      wcoef(0, p, 2, 96 + 14 * p);
      wcoef(0, p, 3, 16 - 2 * p);
      wcoef(0, p, 4, -(1 + p));
    end
    wcoef(0, 0, 6, 77);   // R7: tap code 6 is not a tap
    cur_tag = "R4 R5 R9 full range";
    cfg(1, 1, 0, 300);
    send_line('{0, 255, 3, 250, 128, 128, 60, 200, 5, 0, 255, 90}, 1);
    idle();
    cur_tag = "R5 video range";
    cfg(1, 0, 0, 300);
    send_line('{0, 255, 3, 250, 128, 128, 60, 200, 5, 0, 255, 90}, 1);
    idle();

    // R8: chroma bank differs from luma bank
    cfg(0, 1, 0, 1024);
    for (int p = 0; p < 8; p++) begin
      wcoef(1, p, 0, 5);
      wcoef(1, p, 1, -10 - p);
      wcoef(1, p, 2, 130 + 3 * p);
      wcoef(1, p, 3, -6);
      wcoef(1, p, 4, 9 - p);
    end
    cur_tag = "R8 chroma bank";
    cfg(1, 1, 1, 700);
    send_line('{30, 90, 250, 10, 140, 70, 220, 16, 180}, 1);
    idle();
    cur_tag = "R8 luma bank";
    cfg(1, 1, 0, 700);
    send_line('{30, 90, 250, 10, 140, 70, 220, 16, 180}, 1);
    idle();

    // R7: write while resizing is ignored (model keeps old centre)
    cfg(1, 1, 0, 1024);
    wcoef(0, 0, 2, 0);
    cur_tag = "R7 locked write";
    send_line('{100, 40, 200, 77, 9}, 1);
    idle();

    // R6: bypass, no clamping, last copied
    cur_tag = "R6 passthrough";
    cfg(0, 0, 0, 1024);
    send_line('{0, 255, 7, 241}, 1);
    send_line('{15, 16, 240, 3}, 1);
    idle();

    // R10: maximum line length closes the line without in_last
    cur_tag = "R10 max line";
    cfg(1, 1, 0, 1024);
    begin
      int px[$];
      for (int i = 0; i < MAXP; i++) px.push_back((i * 4) & 255);
      send_line(px, 0);
    end
    idle();
    cur_tag = "R10 following line";
    send_line('{44, 88, 132}, 1);
    idle();

    chk(exp_d.size() == 0, "R2 all expected outputs seen", exp_d.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule